// File: doc/BRIEF.md
# Serial LCD Controller Bus Peripheral

This block sits on a simple 32-bit processor bus and drives a small monochrome graphic panel over a four-wire serial link. The link is write-only. Its four outputs are an active-low chip select, a command/data select line, a serial clock and serial data. Software reaches two word registers, chosen by bus address bits 3:2. Writing the command register sends one byte with the command/data select low. Writing the data register sends a full 32-bit word as four consecutive display column bytes, all with the select line high. The panel's own command set is unchanged. For example, page selection is 0xB0 OR page (0 to 3), and the column is set with 0x10 OR the high nibble followed by 0x00 OR the low nibble. This block only carries those bytes.

Software paces itself by reading bit 0 of the data register, which is a busy flag. A write accepted while the link is idle starts a transfer at once. A write that arrives while busy is acknowledged but dropped. Each bit takes one serial clock period, and that period is a fixed even number of system clock cycles set by a parameter. Chip select frames every transfer with one idle period before the first bit and one after the last bit.

Top module: `lcd_serial_port`

## Requirements
- R1: While reset is high and on the first cycle after it falls: chip select is high, the serial clock is low, the command/data select is low, serial data is low and the busy flag reads 0.
- R2: Every bus access is acknowledged in the cycle in which its enable is high, whether it is a read, a write or a dropped write. No access is acknowledged when the enable is low.
- R3: The register select input chooses the register. Value 0 is the command register and value 1 is the data register. A write with select value 2 or 3 starts no transfer.
- R4: A read with select value 1 returns the busy flag in bit 0 and zeros in bits 31:1. A read with any other select value returns all zeros.
- R5: An accepted command write sends exactly 8 bits, taken from write data bits 7:0 with bit 7 first. The command/data select is low for the whole time chip select is low.
- R6: An accepted data write sends exactly 32 bits. Write data bit 31 goes first and bit 0 last, so byte 31:24 goes out first and each byte goes out with its top bit first. The command/data select is high throughout.
- R7: Serial data changes only while the serial clock is low, so it is stable across each rising edge. Rising edges within a transfer are exactly CLK_DIV system cycles apart.
- R8: The first rising serial clock edge comes 3*CLK_DIV/2 cycles after chip select falls. Chip select rises CLK_DIV cycles after the last falling edge. The serial clock is low whenever chip select is high.
- R9: Busy reads 1 from the cycle after the accepting write until chip select rises. That is (2*N+4)*CLK_DIV/2 cycles, where N is the number of bits sent.
- R10: A write accepted by the bus while busy is dropped. The running transfer keeps its bits and length, and no further transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe for this peripheral |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_word_sel | input | 2 | Bus address bits 3:2: 0 command, 1 data/status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (busy flag in bit 0 of the data register) |
| bus_ack | output | 1 | Access acknowledge, same cycle as bus_en |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_dc | output | 1 | Command/data select: 0 command, 1 display data |
| lcd_sck | output | 1 | Serial clock, idle low |
| lcd_sdo | output | 1 | Serial data, valid on the rising serial clock edge |

## Verification
The bench builds the block with CLK_DIV = 4 and a 32-bit data word, so a command transfer lasts 40 cycles and a data transfer 136. With transfers that short, the bench can sweep all 256 command byte values and a set of data words that covers a single set bit at every one of the 32 positions plus dense and mixed patterns. A pin monitor recovers every bit on the rising serial clock edges and measures the framing gaps and clock spacing against the arithmetic expectations. It also polls busy every cycle, including across a dropped mid-transfer write.

// File: rtl/lcd_serial_pkg.sv
package lcd_serial_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_RSV2 = 2'd2,
    SEL_RSV3 = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/lcd_bus_decode.sv
module lcd_bus_decode
  import lcd_serial_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int CMD_W  = BYTE_W
) (
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [1:0]        bus_word_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              busy,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              start,
  output logic              start_dc,
  output logic              start_wide,
  output logic [DATA_W-1:0] start_word
);
  reg_sel_e sel;
  logic     known_reg;

  assign sel       = reg_sel_e'(bus_word_sel);
  assign known_reg = (sel == SEL_CMD) || (sel == SEL_DATA);
  assign bus_ack   = bus_en;

  // a write while busy is acknowledged but never turned into a start
  assign start      = bus_en && bus_wr && !busy && known_reg;
  assign start_dc   = (sel == SEL_DATA);
  assign start_wide = (sel == SEL_DATA);

  // command byte is left-justified so both kinds leave through the same MSB
  assign start_word = (sel == SEL_DATA) ? bus_wdata
                    : {bus_wdata[CMD_W-1:0], {(DATA_W-CMD_W){1'b0}}};

  assign bus_rdata = (bus_en && !bus_wr && sel == SEL_DATA)
                   ? {{(DATA_W-1){1'b0}}, busy} : '0;
endmodule

// File: rtl/lcd_half_timer.sv
module lcd_half_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == TOP) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == TOP);
endmodule

// File: rtl/lcd_shift_engine.sv
module lcd_shift_engine
  import lcd_serial_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int CMD_W  = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_dc,
  input  logic              start_wide,
  input  logic [DATA_W-1:0] start_word,
  input  logic              tick,
  output logic              busy,
  output logic              cs_n,
  output logic              sck,
  output logic              dc,
  output logic              sdo
);
  // half-period index: 2 lead halves, 2 per bit, 2 tail halves
  localparam int LAST_CMD  = 2 * CMD_W + 3;
  localparam int LAST_DATA = 2 * DATA_W + 3;
  localparam int HIDX_W    = $clog2(LAST_DATA + 1);

  logic [HIDX_W-1:0] hidx;
  logic [HIDX_W-1:0] last_h;
  logic [HIDX_W-1:0] nxt;
  logic [DATA_W-1:0] shreg;
  logic              nxt_high;
  logic              nxt_shift;

  assign nxt       = hidx + 1'b1;
  assign nxt_high  = nxt[0] && (nxt >= HIDX_W'(3)) && (nxt <= last_h - HIDX_W'(2));
  assign nxt_shift = !nxt[0] && (nxt >= HIDX_W'(4)) && (nxt <= last_h - HIDX_W'(3));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cs_n   <= 1'b1;
      sck    <= 1'b0;
      dc     <= 1'b0;
      hidx   <= '0;
      last_h <= '0;
      shreg  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cs_n   <= 1'b0;
      sck    <= 1'b0;
      dc     <= start_dc;
      hidx   <= '0;
      last_h <= start_wide ? HIDX_W'(LAST_DATA) : HIDX_W'(LAST_CMD);
      shreg  <= start_word;
    end else if (busy && tick) begin
      if (hidx == last_h) begin
        busy  <= 1'b0;
        cs_n  <= 1'b1;
        sck   <= 1'b0;
        hidx  <= '0;
        shreg <= '0;
      end else begin
        hidx <= nxt;
        sck  <= nxt_high;
        if (nxt_shift) begin
          shreg <= {shreg[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo = shreg[DATA_W-1];
endmodule

// File: rtl/lcd_serial_port.sv
module lcd_serial_port
  import lcd_serial_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [1:0]        bus_word_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              lcd_cs_n,
  output logic              lcd_dc,
  output logic              lcd_sck,
  output logic              lcd_sdo
);
  localparam int HALF = CLK_DIV / 2;

  logic              busy;
  logic              start;
  logic              start_dc;
  logic              start_wide;
  logic [DATA_W-1:0] start_word;
  logic              tick;

  lcd_bus_decode #(.DATA_W(DATA_W), .CMD_W(BYTE_W)) u_dec (
    .bus_en      (bus_en),
    .bus_wr      (bus_wr),
    .bus_word_sel(bus_word_sel),
    .bus_wdata   (bus_wdata),
    .busy        (busy),
    .bus_ack     (bus_ack),
    .bus_rdata   (bus_rdata),
    .start       (start),
    .start_dc    (start_dc),
    .start_wide  (start_wide),
    .start_word  (start_word)
  );

  lcd_half_timer #(.HALF(HALF)) u_tmr (
    .clk (clk),
    .rst (rst),
    .run (busy),
    .tick(tick)
  );

  lcd_shift_engine #(.DATA_W(DATA_W), .CMD_W(BYTE_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_dc  (start_dc),
    .start_wide(start_wide),
    .start_word(start_word),
    .tick      (tick),
    .busy      (busy),
    .cs_n      (lcd_cs_n),
    .sck       (lcd_sck),
    .dc        (lcd_dc),
    .sdo       (lcd_sdo)
  );
endmodule

// File: rtl/lcd_serial_port_chk.sv
module lcd_serial_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_en,
  input logic       bus_wr,
  input logic [1:0] bus_word_sel,
  input logic       bus_ack,
  input logic       lcd_cs_n,
  input logic       lcd_dc,
  input logic       lcd_sck,
  input logic       lcd_sdo,
  input logic       busy
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (lcd_cs_n && !lcd_sck && !lcd_dc && !lcd_sdo && !busy)); // R1

  AST_ACK_WITH_EN: assert property (@(posedge clk) disable iff (rst)
    bus_en |-> bus_ack); // R2

  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_en |-> !bus_ack); // R2

  AST_DC_HELD: assert property (@(posedge clk) disable iff (rst)
    (!lcd_cs_n && !$past(lcd_cs_n)) |-> $stable(lcd_dc)); // R5

  AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (lcd_sck && $past(lcd_sck)) |-> $stable(lcd_sdo)); // R7

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    lcd_cs_n |-> !lcd_sck); // R8

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    (!busy && bus_en && bus_wr && !bus_word_sel[1]) |=> (busy && !lcd_cs_n)); // R9

  AST_BUSY_SELECTED: assert property (@(posedge clk) disable iff (rst)
    busy |-> !lcd_cs_n); // R9

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_cs_n) |-> !busy); // R9

  AST_RSV_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && bus_en && bus_wr && bus_word_sel[1]) |=> (!busy && lcd_cs_n)); // R3
endmodule

bind lcd_serial_port lcd_serial_port_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_en      (bus_en),
  .bus_wr      (bus_wr),
  .bus_word_sel(bus_word_sel),
  .bus_ack     (bus_ack),
  .lcd_cs_n    (lcd_cs_n),
  .lcd_dc      (lcd_dc),
  .lcd_sck     (lcd_sck),
  .lcd_sdo     (lcd_sdo),
  .busy        (busy)
);

// File: tb/tb_lcd_serial_port.sv
module tb_lcd_serial_port;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_word_sel = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        lcd_cs_n, lcd_dc, lcd_sck, lcd_sdo;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lcd_serial_port #(.CLK_DIV(CLK_DIV), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_word_sel(bus_word_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_sck(lcd_sck), .lcd_sdo(lcd_sdo)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // pin monitor
  logic        m_pcs = 1'b1, m_psck = 1'b0, m_psdo = 1'b0, m_dc0 = 1'b0;
  logic [31:0] m_cap = '0;
  int m_cyc = 0, m_nb = 0, m_first = -1, m_lastrise = -1, m_lastfall = -1;
  int m_space_err = 0, m_sdo_err = 0, m_dc_err = 0, m_tail = 0;
  int m_xfers = 0, m_idle_err = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!lcd_cs_n && m_pcs) begin
        m_cyc = 1; m_nb = 0; m_cap = '0; m_first = -1; m_lastrise = -1;
        m_lastfall = -1; m_space_err = 0; m_sdo_err = 0; m_dc_err = 0;
        m_dc0 = lcd_dc;
      end else if (!lcd_cs_n) begin
        m_cyc++;
        if (lcd_dc !== m_dc0) m_dc_err++;
        if (lcd_sck && !m_psck) begin
          if (m_first < 0) m_first = m_cyc;
          else if (m_cyc - m_lastrise != CLK_DIV) m_space_err++;
          m_lastrise = m_cyc;
          m_cap = {m_cap[30:0], lcd_sdo};
          m_nb++;
        end
        if (!lcd_sck && m_psck) m_lastfall = m_cyc;
        if (lcd_sck && m_psck && (lcd_sdo !== m_psdo)) m_sdo_err++;
      end else if (!m_pcs) begin
        m_tail = (m_cyc + 1) - m_lastfall;
        m_xfers++;
      end
      if (lcd_cs_n && lcd_sck) m_idle_err++;
      m_pcs = lcd_cs_n; m_psck = lcd_sck; m_psdo = lcd_sdo;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_word_sel = sel; bus_wdata = d;
    #1;
    chk(bus_ack === 1'b1, "R2", "write ack", bus_ack, 1);
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_word_sel = sel;
    #1;
    d = bus_rdata;
    chk(bus_ack === 1'b1, "R2", "read ack", bus_ack, 1);
    bus_en = 1'b0;
  endtask

  task automatic poll_busy(output int n);
    logic [31:0] d;
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd1, d);
      if (d[0]) n++;
      else break;
    end
  endtask

  task automatic run_xfer(input logic [1:0] sel, input logic [31:0] w,
                          input int nbits, input logic [31:0] expw,
                          input logic expdc, input string req);
    int s, n, t;
    s = m_xfers;
    wr(sel, w);
    poll_busy(n);
    t = (2 * nbits + 4) * HALF;
    chk(n == t, "R9", "busy cycles", n, t);
    chk(m_xfers == s + 1, req, "transfer count", m_xfers, s + 1);
    chk(m_nb == nbits, req, "bit count", m_nb, nbits);
    chk(m_cap == expw, req, "captured bits", m_cap, expw);
    chk(m_dc0 == expdc && m_dc_err == 0, req, "dc level", m_dc0, expdc);
    chk(m_first - 1 == 3 * HALF, "R8", "cs to first rise", m_first - 1, 3 * HALF);
    chk(m_tail == CLK_DIV, "R8", "last fall to cs rise", m_tail, CLK_DIV);
    chk(m_space_err == 0 && m_sdo_err == 0, "R7", "clock spacing / sdo hold",
        m_space_err + m_sdo_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s, n1, n2;
    repeat (4) @(negedge clk);
    #1;
    chk(lcd_cs_n === 1'b1 && lcd_sck === 1'b0 && lcd_dc === 1'b0 && lcd_sdo === 1'b0,
        "R1", "pins in reset", {lcd_cs_n, lcd_sck, lcd_dc, lcd_sdo}, 4'b1000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(lcd_cs_n === 1'b1 && lcd_sck === 1'b0 && lcd_dc === 1'b0 && lcd_sdo === 1'b0,
        "R1", "pins after reset", {lcd_cs_n, lcd_sck, lcd_dc, lcd_sdo}, 4'b1000);
    rd(2'd1, d);
    chk(d == 32'd0, "R1", "busy after reset", d, 0);
    chk(bus_ack === 1'b0, "R2", "no ack without enable", bus_ack, 0);

    // R5: every command byte, junk in the upper write-data bits
    for (int i = 0; i < 256; i++) begin
      run_xfer(2'd0, {~i[7:0], i[7:0] ^ 8'h5A, 8'h3C, i[7:0]}, 8,
               {24'd0, i[7:0]}, 1'b0, "R5");
    end

    // R6: one set bit at each position, then dense and mixed words
    for (int k = 0; k < 32; k++) begin
      run_xfer(2'd1, 32'd1 << k, 32, 32'd1 << k, 1'b1, "R6");
    end
    run_xfer(2'd1, 32'hFFFF_FFFF, 32, 32'hFFFF_FFFF, 1'b1, "R6");
    run_xfer(2'd1, 32'h0000_0000, 32, 32'h0000_0000, 1'b1, "R6");
    run_xfer(2'd1, 32'h0102_0304, 32, 32'h0102_0304, 1'b1, "R6");
    run_xfer(2'd1, 32'hA55A_0FF0, 32, 32'hA55A_0FF0, 1'b1, "R6");

    // R4: status read values during and after a transfer
    wr(2'd1, 32'h1234_5678);
    rd(2'd0, d);
    chk(d == 32'd0, "R4", "command offset read while busy", d, 0);
    rd(2'd1, d);
    chk(d == 32'd1, "R4", "status read while busy", d, 1);
    rd(2'd3, d);
    chk(d == 32'd0, "R4", "reserved offset read while busy", d, 0);
    poll_busy(n1);
    rd(2'd1, d);
    chk(d == 32'd0, "R4", "status read when idle", d, 0);

    // R3: writes to reserved selects start nothing
    s = m_xfers;
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    repeat (3 * CLK_DIV) @(negedge clk);
    #1;
    chk(lcd_cs_n === 1'b1 && m_xfers == s, "R3", "reserved write started transfer",
        m_xfers, s);
    rd(2'd1, d);
    chk(d == 32'd0, "R3", "busy after reserved write", d, 0);

    // R10: writes while busy are dropped
    s = m_xfers;
    wr(2'd1, 32'hC3A5_1E7F);
    n1 = 0;
    for (int i = 0; i < 20; i++) begin
      rd(2'd1, d);
      if (d[0]) n1++;
    end
    wr(2'd0, 32'h0000_00FF);
    wr(2'd1, 32'h0000_0000);
    poll_busy(n2);
    chk(n1 + 2 + n2 == (2 * 32 + 4) * HALF, "R10", "busy length with dropped writes",
        n1 + 2 + n2, (2 * 32 + 4) * HALF);
    chk(m_cap == 32'hC3A5_1E7F && m_nb == 32, "R10", "bits of running transfer",
        m_cap, 32'hC3A5_1E7F);
    repeat (40) @(negedge clk);
    #1;
    chk(m_xfers == s + 1 && lcd_cs_n === 1'b1, "R10", "transfers after dropped writes",
        m_xfers, s + 1);
    chk(m_idle_err == 0, "R8", "clock high while deselected", m_idle_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule